// File: doc/BRIEF.md
# Lockable Thermal Interrupt Gating Unit

This block decides which temperature alarms may raise the chip's interrupt line. There are three sources: the ambient sensor and two remote diodes. Each one delivers a one-cycle out-of-limit pulse. A per-channel enable decides whether that pulse is latched into a sticky status bit. A group enable and an external global interrupt enable then decide whether any latched, enabled status pulls the active-low interrupt output.

The enable bits live in one 8-bit register at address 82h. The status bits are read at address 41h, and reading them clears them. Both are reached over a plain synchronous register bus with address, write data, write strobe, read strobe and read data.

A lock input freezes the enable register against further writes. Once the lock is taken, it holds until reset.

Top module: `thermint_ctrl`

## Requirements
- R1: After reset the enable register reads 0Eh, the status register reads 00h, int_no is 1, and the block is unlocked.
- R2: The enable register is at address 82h. Bit 0 is the group enable, bit 1 enables ambient, bit 2 enables remote diode 1 and bit 3 enables remote diode 2. Bits 7..4 read 0 and ignore written data.
- R3: temp_evt_i[0] (ambient), temp_evt_i[1] (remote 1) and temp_evt_i[2] (remote 2) set the matching status bit only when that channel's enable bit is 1.
- R4: The status register is at address 41h. Bit 1 is ambient, bit 2 is remote 1 and bit 3 is remote 2; all other bits read 0.
- R5: A status bit stays set until the status register is read. That read returns the prior value and clears it.
- R6: An event that arrives in the same cycle as a status read stays set. The read itself returns the value from before that event.
- R7: int_no is 0 exactly when three conditions hold: the group enable is 1, glb_int_en_i is 1, and some set status bit has its channel enable at 1.
- R8: int_no is registered. It changes on the clock edge after the status or enable change that causes it.
- R9: A write to the enable register is ignored if it comes in the same cycle as lock_i high or in any later cycle. Only reset removes the lock.
- R10: Read data appears on reg_rdata_o in the cycle after the read strobe. Unmapped addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe |
| reg_rdata_o | output | 8 | Read data, valid the cycle after reg_re_i |
| lock_i | input | 1 | Takes the sticky write lock on the enable register |
| glb_int_en_i | input | 1 | Global interrupt enable |
| temp_evt_i | input | 3 | Out-of-limit pulses: ambient, remote 1, remote 2 |
| int_no | output | 1 | Interrupt, active low, registered |

## Verification
The bench sweeps all 16 writable enable values, both global enable values and all 8 event patterns. For each case it compares the latched status and the interrupt level against values it computes itself. A design that latched events from disabled channels, or ignored the group or global gate, would fail that sweep. The remaining checks target the corner cases:
- An event colliding with a clear-on-read. A design that let the clear win would lose the alarm.
- The cycle in which int_no first moves. A combinational output would move one cycle early.
- A write in the same cycle as the lock, and writes after lock_i has dropped. A design that only honoured the lock while lock_i was high would accept them.
- Reserved bits and unmapped reads. These would expose data written into unused storage.

// File: rtl/thermint_pkg.sv
package thermint_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EN   = 2'd1,
    SEL_STAT = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/thermint_en_reg.sv
module thermint_en_reg #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_CH = 3,
  parameter logic [DATA_W-1:0] RST_VAL = 8'h0E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lock_i,
  output logic [DATA_W-1:0] en_o,
  output logic              grp_en_o,
  output logic [NUM_CH-1:0] ch_en_o
);
  localparam int unsigned FIELD_W = NUM_CH + 1;
  localparam logic [DATA_W-1:0] WMASK = {{(DATA_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}};

  logic [DATA_W-1:0] en_q;
  logic              lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= RST_VAL & WMASK;
      lock_q <= 1'b0;
    end else begin
      lock_q <= lock_q | lock_i;
      // lock wins over a write in the same cycle
      if (wr_i && !lock_q && !lock_i) en_q <= wdata_i & WMASK;
    end
  end

  assign en_o     = en_q;
  assign grp_en_o = en_q[0];
  assign ch_en_o  = en_q[NUM_CH:1];

  p_lock_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  p_locked_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q || lock_i) |=> $stable(en_q));
endmodule

// File: rtl/thermint_status.sv
module thermint_status #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic              clr_i,
  output logic [NUM_CH-1:0] stat_o
);
  logic [NUM_CH-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~{NUM_CH{clr_i}}) | (evt_i & ch_en_i);
  end

  assign stat_o = stat_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_gated_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stat_q[i] && !ch_en_i[i]) |=> !stat_q[i]);
    p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[i] && !clr_i) |=> stat_q[i]);
    p_evt_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[i] && ch_en_i[i]) |=> stat_q[i]);
  end
endmodule

// File: rtl/thermint_irq.sv
module thermint_irq #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grp_en_i,
  input  logic              glb_en_i,
  input  logic [NUM_CH-1:0] stat_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  output logic              int_no
);
  logic int_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) int_nq <= 1'b1;
    else         int_nq <= ~(grp_en_i & glb_en_i & (|(stat_i & ch_en_i)));
  end

  assign int_no = int_nq;

  p_grp_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grp_en_i |=> int_no);
  p_glb_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> int_no);
  p_no_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i == '0) |=> int_no);
endmodule

// File: rtl/thermint_ctrl.sv
module thermint_ctrl #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_CH = 3,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h82,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h41,
  parameter logic [DATA_W-1:0] EN_RST    = 8'h0E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              lock_i,
  input  logic              glb_int_en_i,
  input  logic [NUM_CH-1:0] temp_evt_i,
  output logic              int_no
);
  import thermint_pkg::*;

  localparam int unsigned PAD_W = DATA_W - NUM_CH - 1;

  logic [DATA_W-1:0] en_val;
  logic              grp_en;
  logic [NUM_CH-1:0] ch_en;
  logic [NUM_CH-1:0] stat;
  logic [DATA_W-1:0] rdata_q;
  rd_sel_e           sel;

  always_comb begin
    sel = SEL_NONE;
    if (reg_addr_i == EN_ADDR)        sel = SEL_EN;
    else if (reg_addr_i == STAT_ADDR) sel = SEL_STAT;
  end

  thermint_en_reg #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .RST_VAL(EN_RST)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_we_i && sel == SEL_EN),
    .wdata_i (reg_wdata_i),
    .lock_i  (lock_i),
    .en_o    (en_val),
    .grp_en_o(grp_en),
    .ch_en_o (ch_en)
  );

  thermint_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (temp_evt_i),
    .ch_en_i(ch_en),
    .clr_i  (reg_re_i && sel == SEL_STAT),
    .stat_o (stat)
  );

  thermint_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .grp_en_i(grp_en),
    .glb_en_i(glb_int_en_i),
    .stat_i  (stat),
    .ch_en_i (ch_en),
    .int_no  (int_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (reg_re_i) begin
      unique case (sel)
        SEL_EN:   rdata_q <= en_val;
        SEL_STAT: rdata_q <= {{PAD_W{1'b0}}, stat, 1'b0};
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata_o = rdata_q;

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i != EN_ADDR && reg_addr_i != STAT_ADDR) |=> (reg_rdata_o == '0));
  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i == EN_ADDR) |=> (reg_rdata_o[DATA_W-1:NUM_CH+1] == '0));
endmodule

// File: tb/tb_thermint_ctrl.sv
module tb_thermint_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [7:0] rdata;
  logic       lock = 1'b0;
  logic       glb = 1'b0;
  logic [2:0] evt = '0;
  logic       int_n;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] A_EN = 8'h82;
  localparam logic [7:0] A_ST = 8'h41;

  always #10 clk = ~clk;  // 50 MHz

  thermint_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_we_i(we), .reg_re_i(re), .reg_rdata_o(rdata), .lock_i(lock),
    .glb_int_en_i(glb), .temp_evt_i(evt), .int_no(int_n)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h exp %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [2:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    do_reset();

    // R1 reset state
    check("R1 int_no", {7'd0, int_n}, 8'h01);
    rd(A_EN, d); check("R1 enable reset", d, 8'h0E);
    rd(A_ST, d); check("R1 status reset", d, 8'h00);

    // R2 reserved bits
    wr(A_EN, 8'hFF); rd(A_EN, d); check("R2 reserved masked", d, 8'h0F);
    wr(A_EN, 8'hA5); rd(A_EN, d); check("R2 write A5", d, 8'h05);

    // R10 unmapped reads
    rd(8'h00, d); check("R10 unmapped 00", d, 8'h00);
    rd(8'h83, d); check("R10 unmapped 83", d, 8'h00);
    rd(8'hFF, d); check("R10 unmapped FF", d, 8'h00);

    // R3 R4 R7 sweep over enable, global enable, events
    for (int en = 0; en < 16; en++) begin
      for (int g = 0; g < 2; g++) begin
        for (int e = 0; e < 8; e++) begin
          logic [2:0] hit;
          logic       exp_int;
          hit = 3'(e) & 3'(en >> 1);
          exp_int = en[0] && (g == 1) && (hit != 0);
          wr(A_EN, 8'(en));
          glb = g[0];
          rd(A_ST, d);
          pulse(3'(e));
          @(negedge clk);
          check($sformatf("R7 int en=%0h g=%0d e=%0d", en, g, e), {7'd0, int_n}, {7'd0, ~exp_int});
          rd(A_ST, d);
          check($sformatf("R3 R4 status en=%0h e=%0d", en, e), d, {4'd0, hit, 1'b0});
        end
      end
    end

    // R5 sticky and clear-on-read
    glb = 1'b1;
    wr(A_EN, 8'h0F);
    rd(A_ST, d);
    pulse(3'b100);
    repeat (5) @(negedge clk);
    check("R5 still asserted", {7'd0, int_n}, 8'h00);
    rd(A_ST, d); check("R5 sticky value", d, 8'h08);
    rd(A_ST, d); check("R5 cleared by read", d, 8'h00);
    @(negedge clk);
    check("R5 int released", {7'd0, int_n}, 8'h01);

    // R6 event collides with read
    pulse(3'b010);
    addr = A_ST; re = 1'b1; evt = 3'b001;
    @(negedge clk);
    re = 1'b0; evt = '0;
    check("R6 read returns prior", rdata, 8'h04);
    rd(A_ST, d); check("R6 event survived", d, 8'h02);

    // R8 registered interrupt timing
    rd(A_ST, d);
    @(negedge clk);
    pulse(3'b001);
    check("R8 int not yet", {7'd0, int_n}, 8'h01);
    @(negedge clk);
    check("R8 int one clock later", {7'd0, int_n}, 8'h00);
    wr(A_EN, 8'h0D);
    check("R8 mask not yet", {7'd0, int_n}, 8'h00);
    @(negedge clk);
    check("R8 masked after clock", {7'd0, int_n}, 8'h01);
    rd(A_ST, d);

    // R9 lock
    wr(A_EN, 8'h03);
    addr = A_EN; wdata = 8'h0C; we = 1'b1; lock = 1'b1;
    @(negedge clk);
    we = 1'b0; lock = 1'b0;
    rd(A_EN, d); check("R9 same-cycle write ignored", d, 8'h03);
    wr(A_EN, 8'h00); rd(A_EN, d); check("R9 later write ignored", d, 8'h03);
    repeat (3) @(negedge clk);
    wr(A_EN, 8'h0F); rd(A_EN, d); check("R9 lock held", d, 8'h03);

    // R1 reset clears lock
    do_reset();
    rd(A_EN, d); check("R1 enable after reset", d, 8'h0E);
    wr(A_EN, 8'h09); rd(A_EN, d); check("R9 unlocked by reset", d, 8'h09);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule